// File: doc/BRIEF.md
# Operand Hazard Stall Scoreboard

This block decides, each cycle, whether the operation offered for issue in an in-order integer pipeline has to wait for an older result. For every architectural register, and for the condition flags, it keeps a tag naming the class of the last operation that wrote it. It also keeps a saturating count of the cycles since that write. A candidate operation presents up to `NSRC` source registers, each with a role tag, plus a flags-use code. The role says how the value is consumed: as plain data, as an address operand, as a shift count or as the data being shifted. The block looks up the gap that the producer class and that role require. It raises `stall` while any enabled operand is younger than its gap.

A candidate issues in a cycle where `cand_valid` is high and `stall` is low. At that clock edge its destination entry and, if requested, the flags entry are retagged with the candidate's class, and their ages restart. A stalled or withdrawn candidate leaves the scoreboard untouched. The issue logic holds the candidate in place until `stall` drops.

Top module: `hzd_scoreboard`

## Requirements
- R1: After reset every register and the flags are ready, so no candidate stalls in the first cycle after reset, whatever sources or flags use it presents.
- R2: A result of class ALU (code 0, ordinary execute, including shifts) read with role ADDR (code 1) needs a gap of `ADDR_GAP` (default 4) cycles. A consumer offered in the cycle after the producer issues therefore stalls 3 cycles.
- R3: A result of class LEA (code 1, address calculation) read as DATA (role 0) or as ADDR causes no stall.
- R4: A result of class MUL (code 3) needs a gap of `MUL_ADDR_GAP` (default 9) when read as ADDR, and `MUL_LAT` (default 5) for any other use.
- R5: An LEA result needs a gap of 3 when read as a shift count (role SHCNT, code 2), and 2 when read as the shifted data (role SHSRC, code 3).
- R6: An ALU result read as a shift count needs a gap of 2.
- R7: Flags written by an ALU or CMP (code 2) operation need a gap of 2 when `flags_use` is 2 (conditional move or add-with-carry). They need a gap of 1, meaning no stall, when `flags_use` is 1 (conditional branch).
- R8: A result of class DIV (code 4) needs a gap of `DIV_LAT` (default 65) for every role, and no candidate stalls for more than the largest configured gap minus one consecutive cycles.
- R9: Disabled sources and `flags_use` 0 never cause a stall, and a candidate that is stalled or withdrawn does not update its destination entry.
- R10: `stall` is low whenever `cand_valid` is low. With several sources it follows the most restrictive one, and the newest write to a register replaces any older producer's requirement.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cand_valid | input | 1 | A candidate operation is offered this cycle |
| cand_cls | input | 3 | Candidate class: 0 ALU, 1 LEA, 2 CMP, 3 MUL, 4 DIV |
| cand_dst_en | input | 1 | Candidate writes a register |
| cand_dst | input | RW | Destination register index |
| cand_wr_flags | input | 1 | Candidate writes the flags |
| src_en | input | NSRC | Per-source enable |
| src_reg | input | NSRC*RW | Source register indices, source s in bits [s*RW +: RW] |
| src_role | input | NSRC*2 | Source roles: 0 DATA, 1 ADDR, 2 SHCNT, 3 SHSRC |
| flags_use | input | 2 | 0 none, 1 branch, 2 conditional move / carry-in |
| stall | output | 1 | Candidate must wait this cycle |

## Verification
`stall` is a combinational function of the current candidate and of scoreboard state registered at the previous edge. An operation issuing at edge k is seen by a candidate from the cycle after that edge, with an age of 1. A gap of g therefore stalls a back-to-back consumer g-1 cycles. The bench drives inputs at the falling edge and compares `stall` 1 ns later against a model that holds issue cycle numbers. The model advances only at the rising edge, so each comparison sees the state of the preceding edges. Each scenario also counts the stall cycles until issue and compares that count with the gap minus one.

// File: rtl/hzd_pkg.sv
package hzd_pkg;

  typedef enum logic [2:0] {
    PC_ALU = 3'd0,
    PC_LEA = 3'd1,
    PC_CMP = 3'd2,
    PC_MUL = 3'd3,
    PC_DIV = 3'd4
  } prod_cls_e;

  typedef enum logic [2:0] {
    U_DATA   = 3'd0,
    U_ADDR   = 3'd1,
    U_SHCNT  = 3'd2,
    U_SHSRC  = 3'd3,
    U_FLCOND = 3'd4,
    U_FLBR   = 3'd5
  } use_e;

  localparam int unsigned GAP_BASE      = 1;
  localparam int unsigned GAP_ALU_SHCNT = 2;
  localparam int unsigned GAP_LEA_SHCNT = 3;
  localparam int unsigned GAP_LEA_SHSRC = 2;
  localparam int unsigned GAP_FLAG_COND = 2;

  // Cycles between producer issue and the earliest consumer issue.
  function automatic int unsigned req_gap(
    input prod_cls_e   c,
    input use_e        u,
    input int unsigned addr_gap,
    input int unsigned mul_lat,
    input int unsigned mul_addr_gap,
    input int unsigned div_lat
  );
    int unsigned g;
    g = GAP_BASE;
    case (c)
      PC_ALU: begin
        if (u == U_ADDR)        g = addr_gap;
        else if (u == U_SHCNT)  g = GAP_ALU_SHCNT;
        else if (u == U_FLCOND) g = GAP_FLAG_COND;
      end
      PC_LEA: begin
        if (u == U_SHCNT)       g = GAP_LEA_SHCNT;
        else if (u == U_SHSRC)  g = GAP_LEA_SHSRC;
      end
      PC_CMP: begin
        if (u == U_FLCOND)      g = GAP_FLAG_COND;
      end
      PC_MUL: g = (u == U_ADDR) ? mul_addr_gap : mul_lat;
      PC_DIV: g = div_lat;
      default: g = GAP_BASE;
    endcase
    return g;
  endfunction

endpackage

// File: rtl/hzd_ready_slot.sv
module hzd_ready_slot
  import hzd_pkg::*;
#(
  parameter int unsigned AW = 7
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr,
  input  prod_cls_e     wr_cls,
  output prod_cls_e     cls,
  output logic [AW-1:0] age
);

  localparam logic [AW-1:0] AGE_MAX = '1;

  always_ff @(posedge clk) begin
    if (rst) begin
      cls <= PC_ALU;
      age <= AGE_MAX;
    end else if (wr) begin
      cls <= wr_cls;
      age <= AW'(1);
    end else if (age != AGE_MAX) begin
      age <= age + AW'(1);
    end
  end

endmodule

// File: rtl/hzd_use_check.sv
module hzd_use_check
  import hzd_pkg::*;
#(
  parameter int unsigned AW           = 7,
  parameter int unsigned ADDR_GAP     = 4,
  parameter int unsigned MUL_LAT      = 5,
  parameter int unsigned MUL_ADDR_GAP = 9,
  parameter int unsigned DIV_LAT      = 65
) (
  input  logic          en,
  input  prod_cls_e     cls,
  input  logic [AW-1:0] age,
  input  use_e          use_kind,
  output logic          hazard
);

  int unsigned gap;

  always_comb begin
    gap    = req_gap(cls, use_kind, ADDR_GAP, MUL_LAT, MUL_ADDR_GAP, DIV_LAT);
    hazard = en && (32'(age) < gap);
  end

endmodule

// File: rtl/hzd_scoreboard.sv
module hzd_scoreboard
  import hzd_pkg::*;
#(
  parameter int unsigned NREG         = 16,
  parameter int unsigned NSRC         = 2,
  parameter int unsigned ADDR_GAP     = 4,
  parameter int unsigned MUL_LAT      = 5,
  parameter int unsigned MUL_ADDR_GAP = 9,
  parameter int unsigned DIV_LAT      = 65,
  localparam int unsigned RW          = $clog2(NREG)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               cand_valid,
  input  logic [2:0]         cand_cls,
  input  logic               cand_dst_en,
  input  logic [RW-1:0]      cand_dst,
  input  logic               cand_wr_flags,
  input  logic [NSRC-1:0]    src_en,
  input  logic [NSRC*RW-1:0] src_reg,
  input  logic [NSRC*2-1:0]  src_role,
  input  logic [1:0]         flags_use,
  output logic               stall
);

  localparam int unsigned G1     = (DIV_LAT > MUL_ADDR_GAP) ? DIV_LAT : MUL_ADDR_GAP;
  localparam int unsigned G2     = (ADDR_GAP > MUL_LAT) ? ADDR_GAP : MUL_LAT;
  localparam int unsigned G3     = (G1 > G2) ? G1 : G2;
  localparam int unsigned MAXGAP = (G3 > GAP_LEA_SHCNT) ? G3 : GAP_LEA_SHCNT;
  localparam int unsigned AW     = $clog2(MAXGAP + 1);

  prod_cls_e       cls_in;
  logic            issue;
  prod_cls_e       reg_cls [NREG];
  logic [AW-1:0]   reg_age [NREG];
  prod_cls_e       flag_cls;
  logic [AW-1:0]   flag_age;
  logic [NSRC-1:0] src_haz;
  logic            flag_haz;
  use_e            flag_kind;

  assign cls_in = prod_cls_e'(cand_cls);
  assign issue  = cand_valid && !stall;

  // One ready slot per architectural register.
  for (genvar i = 0; i < NREG; i++) begin : g_reg
    hzd_ready_slot #(.AW(AW)) u_slot (
      .clk    (clk),
      .rst    (rst),
      .wr     (issue && cand_dst_en && (cand_dst == RW'(i))),
      .wr_cls (cls_in),
      .cls    (reg_cls[i]),
      .age    (reg_age[i])
    );
  end

  hzd_ready_slot #(.AW(AW)) u_flag_slot (
    .clk    (clk),
    .rst    (rst),
    .wr     (issue && cand_wr_flags),
    .wr_cls (cls_in),
    .cls    (flag_cls),
    .age    (flag_age)
  );

  // Per-source gap check against the slot it names.
  for (genvar s = 0; s < NSRC; s++) begin : g_src
    logic [RW-1:0] idx;
    use_e          kind;
    assign idx  = src_reg[s*RW +: RW];
    assign kind = use_e'({1'b0, src_role[s*2 +: 2]});

    hzd_use_check #(
      .AW(AW), .ADDR_GAP(ADDR_GAP), .MUL_LAT(MUL_LAT),
      .MUL_ADDR_GAP(MUL_ADDR_GAP), .DIV_LAT(DIV_LAT)
    ) u_chk (
      .en       (src_en[s]),
      .cls      (reg_cls[idx]),
      .age      (reg_age[idx]),
      .use_kind (kind),
      .hazard   (src_haz[s])
    );
  end

  assign flag_kind = (flags_use == 2'd1) ? U_FLBR : U_FLCOND;

  hzd_use_check #(
    .AW(AW), .ADDR_GAP(ADDR_GAP), .MUL_LAT(MUL_LAT),
    .MUL_ADDR_GAP(MUL_ADDR_GAP), .DIV_LAT(DIV_LAT)
  ) u_flag_chk (
    .en       (flags_use != 2'd0),
    .cls      (flag_cls),
    .age      (flag_age),
    .use_kind (flag_kind),
    .hazard   (flag_haz)
  );

  assign stall = cand_valid && ((|src_haz) || flag_haz);

endmodule

// File: rtl/hzd_scoreboard_chk.sv
module hzd_scoreboard_chk #(
  parameter int unsigned NREG         = 16,
  parameter int unsigned NSRC         = 2,
  parameter int unsigned ADDR_GAP     = 4,
  parameter int unsigned MUL_LAT      = 5,
  parameter int unsigned MUL_ADDR_GAP = 9,
  parameter int unsigned DIV_LAT      = 65,
  localparam int unsigned RW          = $clog2(NREG)
) (
  input logic               clk,
  input logic               rst,
  input logic               cand_valid,
  input logic [2:0]         cand_cls,
  input logic               cand_dst_en,
  input logic [RW-1:0]      cand_dst,
  input logic               cand_wr_flags,
  input logic [NSRC-1:0]    src_en,
  input logic [NSRC*RW-1:0] src_reg,
  input logic [NSRC*2-1:0]  src_role,
  input logic [1:0]         flags_use,
  input logic               stall
);

  localparam int unsigned G1     = (DIV_LAT > MUL_ADDR_GAP) ? DIV_LAT : MUL_ADDR_GAP;
  localparam int unsigned G2     = (ADDR_GAP > MUL_LAT) ? ADDR_GAP : MUL_LAT;
  localparam int unsigned G3     = (G1 > G2) ? G1 : G2;
  localparam int unsigned MAXGAP = (G3 > 3) ? G3 : 3;
  localparam int unsigned CW     = $clog2(MAXGAP + 1) + 1;

  logic [CW-1:0] run_cnt;
  logic          issued;

  assign issued = cand_valid && !stall;

  always_ff @(posedge clk) begin
    if (rst || !(cand_valid && stall)) run_cnt <= '0;
    else if (run_cnt != '1)            run_cnt <= run_cnt + CW'(1);
  end

  a_r1_ready_after_reset: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> !stall);

  a_r9_no_use_no_stall: assert property (@(posedge clk) disable iff (rst)
    (src_en == '0 && flags_use == 2'd0) |-> !stall);

  a_r10_stall_needs_candidate: assert property (@(posedge clk) disable iff (rst)
    !cand_valid |-> !stall);

  a_r2_alu_to_addr_stalls: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(issued && cand_dst_en && cand_cls == 3'd0)
     && cand_valid && src_en[0] && src_role[1:0] == 2'd1
     && src_reg[RW-1:0] == $past(cand_dst)) |-> stall);

  a_r3_lea_to_data_free: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(issued && cand_dst_en && cand_cls == 3'd1)
     && cand_valid && src_en == NSRC'(1) && src_role[1:0] == 2'd0
     && src_reg[RW-1:0] == $past(cand_dst) && flags_use == 2'd0) |-> !stall);

  a_r7_flags_to_cond_stalls: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(issued && cand_wr_flags && (cand_cls == 3'd0 || cand_cls == 3'd2))
     && cand_valid && flags_use == 2'd2) |-> stall);

  a_r8_stall_run_bounded: assert property (@(posedge clk) disable iff (rst)
    (cand_valid && stall) |-> (32'(run_cnt) < MAXGAP));

endmodule

bind hzd_scoreboard hzd_scoreboard_chk #(
  .NREG(NREG), .NSRC(NSRC), .ADDR_GAP(ADDR_GAP), .MUL_LAT(MUL_LAT),
  .MUL_ADDR_GAP(MUL_ADDR_GAP), .DIV_LAT(DIV_LAT)
) u_chk (
  .clk(clk), .rst(rst), .cand_valid(cand_valid), .cand_cls(cand_cls),
  .cand_dst_en(cand_dst_en), .cand_dst(cand_dst), .cand_wr_flags(cand_wr_flags),
  .src_en(src_en), .src_reg(src_reg), .src_role(src_role),
  .flags_use(flags_use), .stall(stall)
);

// File: tb/hzd_scoreboard_bench.sv
`timescale 1ns/1ps
module hzd_scoreboard_bench;

  localparam int NREG = 16;
  localparam int RW   = 4;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         cand_valid = 1'b0;
  logic [2:0]   cand_cls = '0;
  logic         cand_dst_en = 1'b0;
  logic [RW-1:0] cand_dst = '0;
  logic         cand_wr_flags = 1'b0;
  logic [1:0]   src_en = '0;
  logic [2*RW-1:0] src_reg = '0;
  logic [3:0]   src_role = '0;
  logic [1:0]   flags_use = '0;
  logic         stall;

  always #10 clk = ~clk;

  hzd_scoreboard u_hzd_scoreboard (
    .clk(clk), .rst(rst), .cand_valid(cand_valid), .cand_cls(cand_cls),
    .cand_dst_en(cand_dst_en), .cand_dst(cand_dst), .cand_wr_flags(cand_wr_flags),
    .src_en(src_en), .src_reg(src_reg), .src_role(src_role),
    .flags_use(flags_use), .stall(stall)
  );

  int    nchk = 0;
  int    nerr = 0;
  int    cyc  = 0;
  int    m_iss [NREG];
  int    m_cls [NREG];
  int    f_iss = -1000;
  int    f_cls = 0;
  bit    last_stall;
  string cur_tag = "R1";

  // Classes: 0 ALU 1 LEA 2 CMP 3 MUL 4 DIV. Uses: 0 data 1 addr 2 shcnt 3 shsrc 4 flag-cond 5 flag-branch.
  function automatic int gap(int c, int u);
    if (c == 4) return 65;
    if (c == 3) return (u == 1) ? 9 : 5;
    if (c == 0) begin
      if (u == 1) return 4;
      if (u == 2 || u == 4) return 2;
      return 1;
    end
    if (c == 1) begin
      if (u == 2) return 3;
      if (u == 3) return 2;
      return 1;
    end
    if (c == 2 && u == 4) return 2;
    return 1;
  endfunction

  function automatic bit model_stall();
    bit s;
    s = 1'b0;
    if (!cand_valid) return 1'b0;
    for (int k = 0; k < 2; k++) begin
      if (src_en[k]) begin
        int r;
        r = int'(src_reg[k*RW +: RW]);
        if (cyc - m_iss[r] < gap(m_cls[r], int'(src_role[k*2 +: 2]))) s = 1'b1;
      end
    end
    if (flags_use != 2'd0)
      if (cyc - f_iss < gap(f_cls, (flags_use == 2'd1) ? 5 : 4)) s = 1'b1;
    return s;
  endfunction

  task automatic check(string tag, int act, int exp);
    nchk++;
    if (act != exp) begin
      nerr++;
      $display("FAIL %s: got %0d expected %0d (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  // Called at a falling edge with inputs settled.
  task automatic tick();
    bit exp;
    #1;
    exp = model_stall();
    check(cur_tag, int'(stall), int'(exp));
    last_stall = stall;
    @(posedge clk);
    if (cand_valid && !exp) begin
      if (cand_dst_en) begin
        m_iss[cand_dst] = cyc;
        m_cls[cand_dst] = int'(cand_cls);
      end
      if (cand_wr_flags) begin
        f_iss = cyc;
        f_cls = int'(cand_cls);
      end
    end
    cyc++;
    @(negedge clk);
  endtask

  task automatic set_op(int c, bit de, int d, bit wf,
                        bit e0, int r0, int ro0, bit e1, int r1, int ro1, int fu);
    cand_valid    = 1'b1;
    cand_cls      = 3'(c);
    cand_dst_en   = de;
    cand_dst      = RW'(d);
    cand_wr_flags = wf;
    src_en        = {e1, e0};
    src_reg       = {RW'(r1), RW'(r0)};
    src_role      = {2'(ro1), 2'(ro0)};
    flags_use     = 2'(fu);
  endtask

  task automatic run(int exp_stalls, string tag);
    int n;
    cur_tag = tag;
    n = 0;
    tick();
    while (last_stall && n < 300) begin
      n++;
      tick();
    end
    check(tag, n, exp_stalls);
    cand_valid = 1'b0;
  endtask

  task automatic idle(int k);
    cand_valid = 1'b0;
    repeat (k) tick();
  endtask

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  endtask

  initial begin
    repeat (60000) @(posedge clk);
    nerr++;
    $display("FAIL watchdog: got timeout expected completion");
    summary();
  end

  initial begin
    for (int i = 0; i < NREG; i++) begin
      m_iss[i] = -1000;
      m_cls[i] = 0;
    end
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;

    // R1: everything ready right after reset.
    set_op(0, 1, 0, 0, 1, 1, 1, 1, 2, 2, 2);
    run(0, "R1");
    idle(2);

    // R2: ALU result as address operand.
    set_op(0, 1, 3, 0, 0, 0, 0, 0, 0, 0, 0); run(0, "R2 producer");
    set_op(1, 1, 4, 0, 1, 3, 1, 0, 0, 0, 0); run(3, "R2");
    idle(70);

    // R3: LEA result as data and as address.
    set_op(1, 1, 4, 0, 0, 0, 0, 0, 0, 0, 0); run(0, "R3 producer");
    set_op(0, 1, 6, 0, 1, 4, 0, 0, 0, 0, 0); run(0, "R3 data");
    set_op(1, 1, 5, 0, 0, 0, 0, 0, 0, 0, 0); run(0, "R3 producer");
    set_op(1, 1, 7, 0, 1, 5, 1, 0, 0, 0, 0); run(0, "R3 addr");
    idle(70);

    // R4: multiply to address and to data.
    set_op(3, 1, 6, 0, 0, 0, 0, 0, 0, 0, 0); run(0, "R4 producer");
    set_op(0, 1, 8, 0, 1, 6, 1, 0, 0, 0, 0); run(8, "R4 addr");
    set_op(3, 1, 7, 0, 0, 0, 0, 0, 0, 0, 0); run(0, "R4 producer");
    set_op(0, 1, 9, 0, 1, 7, 0, 0, 0, 0, 0); run(4, "R4 data");
    idle(70);

    // R5: LEA as shift count and shift source.
    set_op(1, 1, 8, 0, 0, 0, 0, 0, 0, 0, 0); run(0, "R5 producer");
    set_op(0, 1, 1, 0, 1, 8, 2, 0, 0, 0, 0); run(2, "R5 shcnt");
    set_op(1, 1, 9, 0, 0, 0, 0, 0, 0, 0, 0); run(0, "R5 producer");
    set_op(0, 1, 1, 0, 1, 9, 3, 0, 0, 0, 0); run(1, "R5 shsrc");
    idle(70);

    // R6: ALU result as shift count.
    set_op(0, 1, 10, 0, 0, 0, 0, 0, 0, 0, 0); run(0, "R6 producer");
    set_op(0, 1, 1, 0, 1, 10, 2, 0, 0, 0, 0); run(1, "R6");
    idle(70);

    // R7: flags to conditional move / carry and to branch.
    set_op(2, 0, 0, 1, 0, 0, 0, 0, 0, 0, 0); run(0, "R7 producer");
    set_op(0, 1, 1, 0, 0, 0, 0, 0, 0, 0, 2); run(1, "R7 cmp cond");
    set_op(2, 0, 0, 1, 0, 0, 0, 0, 0, 0, 0); run(0, "R7 producer");
    set_op(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 1); run(0, "R7 branch");
    set_op(0, 1, 2, 1, 0, 0, 0, 0, 0, 0, 0); run(0, "R7 producer");
    set_op(0, 1, 1, 0, 0, 0, 0, 0, 0, 0, 2); run(1, "R7 alu cond");
    idle(70);

    // R8: divide to data.
    set_op(4, 1, 11, 0, 0, 0, 0, 0, 0, 0, 0); run(0, "R8 producer");
    set_op(0, 1, 1, 0, 1, 11, 0, 0, 0, 0, 0); run(64, "R8");
    idle(70);

    // R9: stalled then withdrawn candidate must not claim r13.
    set_op(0, 1, 12, 0, 0, 0, 0, 0, 0, 0, 0); run(0, "R9 producer");
    cur_tag = "R9 stalled";
    set_op(4, 1, 13, 1, 1, 12, 1, 0, 0, 0, 0);
    tick();
    tick();
    cand_valid = 1'b0;
    set_op(0, 1, 1, 0, 1, 13, 0, 0, 0, 0, 2); run(0, "R9 no write");
    // R9: disabled source pointing at a fresh multiply, flags unused.
    set_op(3, 1, 14, 0, 0, 0, 0, 0, 0, 0, 0); run(0, "R9 producer");
    set_op(0, 1, 1, 0, 0, 14, 1, 0, 14, 0, 0); run(0, "R9 disabled");
    idle(70);

    // R10: two sources, most restrictive wins.
    set_op(0, 1, 1, 0, 0, 0, 0, 0, 0, 0, 0); run(0, "R10 producer");
    set_op(3, 1, 2, 0, 0, 0, 0, 0, 0, 0, 0); run(0, "R10 producer");
    set_op(0, 1, 5, 0, 1, 1, 0, 1, 2, 1, 0); run(8, "R10 max");
    idle(70);
    // R10: newest writer replaces an older multiply.
    set_op(3, 1, 14, 0, 0, 0, 0, 0, 0, 0, 0); run(0, "R10 producer");
    set_op(0, 1, 14, 0, 0, 0, 0, 0, 0, 0, 0); run(0, "R10 producer");
    set_op(0, 1, 5, 0, 1, 14, 0, 0, 0, 0, 0); run(0, "R10 overwrite");
    idle(4);

    summary();
  end

endmodule